// File: doc/BRIEF.md
# DMA Channel Interrupt Coalescer

This block sits beside one DMA channel and decides when the channel's completion events should reach the processor. Rather than interrupting on every finished packet, it counts completions down from a programmed threshold and raises a completion interrupt only when the count is used up. A one-shot delay timer covers the quiet tail of a burst. If the timer runs out before another completion arrives, it raises a separate timeout interrupt, so that a partial batch is still reported.

The channel's control word is fed in live. The threshold, the delay and the per-source interrupt enables are taken from fixed fields of that word, and a strobe marks each write to it. Three pending bits (completion, timeout and error) are held here and cleared one by one by strobes. They are masked by the enables and combined into one interrupt line. The live count and timer value are exposed so that a status register elsewhere can report them. The timer is clocked by an internal prescaler, which restarts whenever the timer is loaded.

Top module: `irqc_top`

## Requirements
- R1: After reset the pending bits are 000, the count is 1, the timer is 0 and the interrupt line is low.
- R2: Each completion pulse decrements the count by one. When a completion arrives with the count at 1, pending bit 0 (completion) sets and the count reloads from control bits 23:16.
- R3: With the count at 0, a completion wraps the count to 255 and sets no pending bit.
- R4: A control write strobe reloads the count from control bits 23:16. If a completion arrives in the same cycle, the write wins: the count takes the threshold and pending bit 0 does not set.
- R5: A completion loads the timer with control bits 31:24 when that field is nonzero. When the field is zero, the timer is left unchanged.
- R6: The timer decrements once every PRESCALE clocks, counted from the cycle it was loaded. On the step from 1 to 0, pending bit 1 (timeout) sets and the count reloads from the threshold.
- R7: A completion that arrives while the timer runs restarts it from the delay value, and no timeout occurs for the earlier load.
- R8: An error pulse sets pending bit 2.
- R9: Each bit of the clear strobe clears the matching pending bit. A set and a clear of the same bit in one cycle leave the bit set.
- R10: The interrupt line is high exactly when some pending bit i is set and its enable, control bit 12+i, is also set.
- R11: The count and timer outputs show the live 8-bit values at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | One-cycle pulse for each packet completion |
| err_i | input | 1 | One-cycle error event pulse |
| ctrl_i | input | 32 | Live control word: enables at 14:12, threshold at 23:16, delay at 31:24 |
| ctrl_wr_i | input | 1 | Strobe that marks a write to the control word |
| clr_i | input | 3 | Per-bit clear strobes for the pending bits |
| pend_o | output | 3 | Pending bits: 0 completion, 1 timeout, 2 error |
| count_o | output | 8 | Live threshold count |
| timer_o | output | 8 | Live delay timer value |
| irq_o | output | 1 | Masked interrupt line |

## Verification
The threshold path is driven with single completions and with threshold values of 1, 3 and 0. These show the completion interrupt firing on exactly the right completion, and they separate a wrap to 255 from a spurious reload. The delay path is tested with a single completion, which is left to expire, and with a second completion that lands mid-countdown. This separates a restarting timer from one that keeps running, and the exact cycle of expiry confirms the prescaler phase. Collisions are driven in the same cycle: a completion against a control write, and a set against a clear. These show the priority rules. Masking is checked by toggling the enables while a bit is pending.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int CNT_W    = 8;
  localparam int PEND_W   = 3;
  localparam int EN_LSB   = 12;
  localparam int THR_LSB  = 16;
  localparam int DLY_LSB  = 24;

  localparam int P_IOC = 0;
  localparam int P_DLY = 1;
  localparam int P_ERR = 2;

  typedef struct packed {
    logic [CNT_W-1:0]  delay;
    logic [CNT_W-1:0]  thresh;
    logic [PEND_W-1:0] en;
  } ctrl_fields_t;

  function automatic ctrl_fields_t decode_ctrl(input logic [31:0] w);
    ctrl_fields_t f;
    f.delay  = w[DLY_LSB +: CNT_W];
    f.thresh = w[THR_LSB +: CNT_W];
    f.en     = w[EN_LSB +: PEND_W];
    return f;
  endfunction
endpackage

// File: rtl/irqc_prescaler.sv
`timescale 1ns/1ps
module irqc_prescaler #(
  parameter int PRESCALE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  AST_PS_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/irqc_delay_tmr.sv
`timescale 1ns/1ps
module irqc_delay_tmr
  import irqc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic             tick_i,
  output logic             load_o,
  output logic             expire_o,
  output logic [CNT_W-1:0] timer_o
);
  logic [CNT_W-1:0] timer_q;

  assign load_o   = done_i && (delay_i != '0);
  assign expire_o = !load_o && tick_i && (timer_q == CNT_W'(1));
  assign timer_o  = timer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          timer_q <= '0;
    else if (load_o)                      timer_q <= delay_i;
    else if (tick_i && timer_q != '0)     timer_q <= timer_q - 1'b1;
  end

  AST_TMR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && delay_i != '0) |=> (timer_q == $past(delay_i))); // R5
  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !tick_i) |=> $stable(timer_q)); // R6
endmodule

// File: rtl/irqc_thresh_cnt.sv
`timescale 1ns/1ps
module irqc_thresh_cnt
  import irqc_pkg::*;
#(
  parameter int RST_COUNT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             done_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             ioc_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;

  assign ioc_o   = done_i && !ctrl_wr_i && (count_q == CNT_W'(1));
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= CNT_W'(RST_COUNT);
    else if (ctrl_wr_i) count_q <= thresh_i;
    else if (done_i) begin
      if (count_q == CNT_W'(1)) count_q <= thresh_i;
      else                      count_q <= count_q - 1'b1;   // 0 wraps
    end
    else if (reload_i)  count_q <= thresh_i;
  end

  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !ctrl_wr_i && count_q != CNT_W'(1)) |=> (count_q == $past(count_q) - 1'b1)); // R2
  AST_CNT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (count_q == $past(thresh_i))); // R4
endmodule

// File: rtl/irqc_pending.sv
`timescale 1ns/1ps
module irqc_pending
  import irqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PEND_W-1:0] set_i,
  input  logic [PEND_W-1:0] clr_i,
  output logic [PEND_W-1:0] pend_o
);
  for (genvar i = 0; i < PEND_W; i++) begin : g_bit
    logic p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       p_q <= 1'b0;
      else if (set_i[i]) p_q <= 1'b1;
      else if (clr_i[i]) p_q <= 1'b0;
    end
    assign pend_o[i] = p_q;

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> p_q); // R9
  end
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
  import irqc_pkg::*;
#(
  parameter int PRESCALE  = 4,
  parameter int RST_COUNT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              err_i,
  input  logic [31:0]       ctrl_i,
  input  logic              ctrl_wr_i,
  input  logic [PEND_W-1:0] clr_i,
  output logic [PEND_W-1:0] pend_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  timer_o,
  output logic              irq_o
);
  ctrl_fields_t     cf;
  logic             tick, load, expire, ioc;
  logic [PEND_W-1:0] set_v;
  logic             unused_ctrl;

  assign cf          = decode_ctrl(ctrl_i);
  assign unused_ctrl = ^{ctrl_i[15], ctrl_i[11:0]};

  irqc_prescaler #(.PRESCALE(PRESCALE)) u_ps (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(load), .tick_o(tick));

  irqc_delay_tmr u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i), .delay_i(cf.delay),
    .tick_i(tick), .load_o(load), .expire_o(expire), .timer_o(timer_o));

  irqc_thresh_cnt #(.RST_COUNT(RST_COUNT)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_wr_i(ctrl_wr_i), .done_i(done_i),
    .reload_i(expire), .thresh_i(cf.thresh), .ioc_o(ioc), .count_o(count_o));

  always_comb begin
    set_v        = '0;
    set_v[P_IOC] = ioc;
    set_v[P_DLY] = expire;
    set_v[P_ERR] = err_i;
  end

  irqc_pending u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_v), .clr_i(clr_i), .pend_o(pend_o));

  assign irq_o = |(pend_o & cf.en);

  AST_IOC_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o[P_IOC]) |-> $past(done_i)); // R2
  AST_DLY_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o[P_DLY]) |-> ($past(timer_o) == CNT_W'(1) && timer_o == '0)); // R6
  AST_ERR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o[P_ERR]) |-> $past(err_i)); // R8
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_o != '0)); // R10
endmodule

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
  localparam int PRESCALE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done = 1'b0, err = 1'b0, ctrl_wr = 1'b0;
  logic [31:0] ctrl = '0;
  logic [2:0]  clr = '0;
  logic [2:0]  pend;
  logic [7:0]  count, timer;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top #(.PRESCALE(PRESCALE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done), .err_i(err), .ctrl_i(ctrl),
    .ctrl_wr_i(ctrl_wr), .clr_i(clr), .pend_o(pend), .count_o(count),
    .timer_o(timer), .irq_o(irq));

  function automatic logic [31:0] mk(input logic [7:0] dly, input logic [7:0] thr,
                                     input logic [2:0] en);
    return {dly, thr, 1'b0, en, 12'h000};
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    ctrl = v; ctrl_wr = 1'b1; step(1); ctrl_wr = 1'b0;
  endtask

  task automatic pulse_done();
    done = 1'b1; step(1); done = 1'b0;
  endtask

  task automatic clear_all();
    clr = 3'b111; step(1); clr = 3'b000;
  endtask

  task automatic t_reset();
    chk("R1 pend", pend, 0); chk("R1 count", count, 1);
    chk("R1 timer", timer, 0); chk("R1 irq", irq, 0);
  endtask

  task automatic t_threshold();
    wr_ctrl(mk(8'd0, 8'd3, 3'b001));
    chk("R4 reload", count, 3);
    pulse_done(); chk("R2 dec1", count, 2); chk("R2 no ioc", pend[0], 0);
    pulse_done(); chk("R11 dec2", count, 1);
    pulse_done(); chk("R2 ioc", pend[0], 1); chk("R2 reload", count, 3);
    chk("R10 irq on", irq, 1);
    clr = 3'b001; step(1); clr = 3'b000;
    chk("R9 cleared", pend[0], 0); chk("R10 irq off", irq, 0);
  endtask

  task automatic t_mask();
    wr_ctrl(mk(8'd0, 8'd1, 3'b000));
    pulse_done();
    chk("R10 masked pend", pend[0], 1); chk("R10 masked irq", irq, 0);
    ctrl = mk(8'd0, 8'd1, 3'b001); #1;
    chk("R10 enable live", irq, 1);
    step(1); clear_all();
  endtask

  task automatic t_set_wins();
    wr_ctrl(mk(8'd0, 8'd1, 3'b001));
    done = 1'b1; clr = 3'b001; step(1); done = 1'b0; clr = 3'b000;
    chk("R9 set wins", pend[0], 1); chk("R2 thr1 count", count, 1);
    clear_all();
  endtask

  task automatic t_zero_thresh();
    wr_ctrl(mk(8'd0, 8'd0, 3'b001));
    chk("R4 zero thr", count, 0);
    pulse_done(); chk("R3 wrap", count, 255); chk("R3 no ioc", pend[0], 0);
  endtask

  task automatic t_wr_collide();
    wr_ctrl(mk(8'd0, 8'd5, 3'b001));
    pulse_done(); pulse_done(); chk("R2 mid", count, 3);
    wr_ctrl(mk(8'd0, 8'd7, 3'b001)); chk("R4 mid reload", count, 7);
    ctrl = mk(8'd0, 8'd2, 3'b001); ctrl_wr = 1'b1; done = 1'b1;
    step(1); ctrl_wr = 1'b0; done = 1'b0;
    chk("R4 wr wins", count, 2); chk("R4 no ioc", pend[0], 0);
  endtask

  task automatic t_delay();
    wr_ctrl(mk(8'd3, 8'd3, 3'b010));
    pulse_done();
    chk("R5 load", timer, 3); chk("R2 cnt", count, 2);
    step(3); chk("R6 hold", timer, 3);
    step(1); chk("R6 dec", timer, 2);
    step(7); chk("R6 at1", timer, 1); chk("R6 not yet", pend[1], 0);
    step(1); chk("R6 zero", timer, 0); chk("R6 pend", pend[1], 1);
    chk("R6 reload", count, 3); chk("R10 dly irq", irq, 1);
    clear_all();
  endtask

  task automatic t_restart();
    pulse_done(); chk("R5 load2", timer, 3);
    step(6); chk("R6 mid", timer, 2);
    pulse_done(); chk("R7 restart", timer, 3); chk("R7 count", count, 1);
    step(11); chk("R7 no early", pend[1], 0); chk("R7 at1", timer, 1);
    step(1); chk("R7 expire", pend[1], 1); chk("R7 reload", count, 3);
    clear_all();
  endtask

  task automatic t_zero_delay();
    wr_ctrl(mk(8'd0, 8'd4, 3'b000));
    pulse_done(); chk("R5 zero delay", timer, 0);
    step(20); chk("R5 no timeout", pend[1], 0);
  endtask

  task automatic t_error();
    ctrl = mk(8'd0, 8'd4, 3'b000);
    err = 1'b1; step(1); err = 1'b0;
    chk("R8 pend", pend[2], 1); chk("R8 masked", irq, 0);
    ctrl = mk(8'd0, 8'd4, 3'b100); #1;
    chk("R8 irq", irq, 1);
    step(1);
    clr = 3'b100; step(1); clr = 3'b000;
    chk("R9 err clr", pend[2], 0);
  endtask

  initial begin
    step(3); rst_n = 1'b1; step(1);
    t_reset();
    t_threshold();
    t_mask();
    t_set_wins();
    t_zero_thresh();
    t_wr_collide();
    t_delay();
    t_restart();
    t_zero_delay();
    t_error();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule